// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a simple processor core and decides which interrupt source, if any, the core takes next. It has two kinds of source. Event sources set a pending flag that is held until the handler is entered or software clears it. Level sources have no flag and request only while their input is high. Each source has its own enable bit. A global enable gates all acceptance.

Acceptance happens only at an instruction boundary reported by the core. Once a request is accepted, the controller raises its request line and holds a vector index and a vector address steady until the core acknowledges. The acknowledge marks entry to the handler. On entry the global enable drops, and the flag of an event source that was taken is cleared. A return instruction sets the global enable again. The controller never accepts a request in the cycle of that return, so at least one main-program instruction retires first. A disable instruction blocks acceptance in its own cycle.

Software reaches the block through a small write port. Address 0 holds the enables, address 1 clears flags by writing ones, and address 2 is the control word.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Source i has vector index i+1, and vector 0 is reserved for reset. Event sources take indices 0..NUM_FLAG-1 and level sources follow them. When several sources request, the lowest source index wins.
- R2: A request is accepted only in a cycle where all of these hold: `insn_bnd_i` is high, the global enable is set, `irq_o` is low, and neither `cli_i` nor `reti_i` is high. `irq_o` rises on the next edge. `vec_idx_o` and `vec_addr_o` then stay stable until the cycle after `ack_i`.
- R3: While `irq_o` is high, `ack_i` causes three things on the next edge: `irq_o` falls, the global enable clears, and the flag of the taken event source clears. A new event on that source in the same cycle leaves its flag set.
- R4: `reti_i` sets the global enable on the next edge. No request is accepted in the `reti_i` cycle, even when the enable is already set.
- R5: `cli_i` blocks acceptance in its own cycle and clears the global enable on the next edge.
- R6: An event sets its flag whether or not its enable or the global enable is on. The flag then holds until it is serviced or cleared by a write.
- R7: A write to address 1 clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R8: A level source keeps no state. A pulse that ends while the source is disabled never produces a request.
- R9: A write to address 0 loads the enables, with bit i enabling source i. A write to address 2 loads the global enable from bit 0 and the relocation bit from bit 1. Either write takes effect on the next edge.
- R10: `vec_addr_o` equals the index times VEC_STRIDE, plus RELOC_BASE when the relocation bit is set. The address is latched at acceptance.
- R11: After reset, `irq_o`, the vector outputs, all flags, all enables, the global enable and the relocation bit are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_FLAG | Event pulses for the flag-type sources |
| lvl_i | input | NUM_LEVEL | Level requests for the flagless sources |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 enables, 1 flag clear, 2 control |
| reg_wdata_i | input | NUM_FLAG+NUM_LEVEL | Register write data |
| insn_bnd_i | input | 1 | An instruction retires this cycle |
| ack_i | input | 1 | Core enters the handler |
| reti_i | input | 1 | Return instruction retires this cycle |
| cli_i | input | 1 | Disable instruction executes this cycle |
| irq_o | output | 1 | Accepted request waiting for acknowledge |
| vec_idx_o | output | clog2(N+1) | Vector index of the accepted source |
| vec_addr_o | output | ADDR_W | Vector address of the accepted source |
| pend_o | output | NUM_FLAG | Current pending flags |
| gie_o | output | 1 | Current global enable |

## Verification
The bench uses four event sources and two level sources, so priority can be tested across both kinds and the highest index belongs to a level source. It uses a vector stride of 2 and a relocation base of 0x400. Because the base lies above every unrelocated address, a missing or stale relocation term is visible at the output. With these values the bench can cover several more cases: masked events that persist, level pulses that are lost, ack colliding with a fresh event, and the return and disable cycles, including a return taken while nesting is enabled.

// File: rtl/vec_irq_ctrl.sv
`timescale 1ns/1ps
module vec_irq_ctrl #(
  parameter int NUM_FLAG   = 4,
  parameter int NUM_LEVEL  = 2,
  parameter int ADDR_W     = 12,
  parameter int VEC_STRIDE = 2,
  parameter int RELOC_BASE = 'h400
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [NUM_FLAG-1:0]                     evt_i,
  input  logic [NUM_LEVEL-1:0]                    lvl_i,
  input  logic                                    reg_we_i,
  input  logic [1:0]                              reg_addr_i,
  input  logic [NUM_FLAG+NUM_LEVEL-1:0]           reg_wdata_i,
  input  logic                                    insn_bnd_i,
  input  logic                                    ack_i,
  input  logic                                    reti_i,
  input  logic                                    cli_i,
  output logic                                    irq_o,
  output logic [$clog2(NUM_FLAG+NUM_LEVEL+1)-1:0] vec_idx_o,
  output logic [ADDR_W-1:0]                       vec_addr_o,
  output logic [NUM_FLAG-1:0]                     pend_o,
  output logic                                    gie_o
);
  localparam int NSRC  = NUM_FLAG + NUM_LEVEL;
  localparam int IDX_W = $clog2(NSRC + 1);

  logic [NUM_FLAG-1:0] flag_q, flag_d;
  logic [NSRC-1:0]     en_q, req;
  logic                gie_q, reloc_q, irq_q;
  logic [IDX_W-1:0]    idx_q, win_idx;
  logic [ADDR_W-1:0]   addr_q, win_addr;

  wire en_wr   = reg_we_i && reg_addr_i == 2'd0;
  wire clr_wr  = reg_we_i && reg_addr_i == 2'd1;
  wire ctrl_wr = reg_we_i && reg_addr_i == 2'd2;
  wire take    = irq_q && ack_i;

  assign req = {lvl_i, flag_q} & en_q;

  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (req[i]) win_idx = IDX_W'(i + 1);
  end

  assign win_addr = ADDR_W'(win_idx) * ADDR_W'(VEC_STRIDE)
                  + (reloc_q ? ADDR_W'(RELOC_BASE) : '0);

  wire accept = insn_bnd_i && gie_q && !irq_q && !cli_i && !reti_i && |req;

  for (genvar g = 0; g < NUM_FLAG; g++) begin : g_flag
    wire sw_clr = clr_wr && reg_wdata_i[g];
    wire hw_clr = take && idx_q == IDX_W'(g + 1);
    assign flag_d[g] = evt_i[g] | (flag_q[g] & ~sw_clr & ~hw_clr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= '0;
      en_q    <= '0;
      gie_q   <= 1'b0;
      reloc_q <= 1'b0;
      irq_q   <= 1'b0;
      idx_q   <= '0;
      addr_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (en_wr) en_q <= reg_wdata_i;
      if (ctrl_wr) reloc_q <= reg_wdata_i[1];
      if (take || cli_i)  gie_q <= 1'b0;
      else if (reti_i)    gie_q <= 1'b1;
      else if (ctrl_wr)   gie_q <= reg_wdata_i[0];
      if (accept) begin
        irq_q  <= 1'b1;
        idx_q  <= win_idx;
        addr_q <= win_addr;
      end else if (take) begin
        irq_q  <= 1'b0;
        idx_q  <= '0;
        addr_q <= '0;
      end
    end
  end

  assign irq_o      = irq_q;
  assign vec_idx_o  = idx_q;
  assign vec_addr_o = addr_q;
  assign pend_o     = flag_q;
  assign gie_o      = gie_q;
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
`timescale 1ns/1ps
module vec_irq_ctrl_chk #(
  parameter int NUM_FLAG = 4,
  parameter int IDX_W    = 3,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we_i,
  input logic                insn_bnd_i,
  input logic                ack_i,
  input logic                reti_i,
  input logic                cli_i,
  input logic                irq_o,
  input logic [IDX_W-1:0]    vec_idx_o,
  input logic [ADDR_W-1:0]   vec_addr_o,
  input logic [NUM_FLAG-1:0] pend_o,
  input logic                gie_o
);
  // R1
  idx_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> vec_idx_o != '0);
  // R2
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !ack_i |=> irq_o && $stable(vec_idx_o) && $stable(vec_addr_o));
  // R2
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(gie_o) && $past(insn_bnd_i));
  // R3
  entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && ack_i |=> !irq_o && !gie_o);
  // R4
  reti_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti_i |=> !$rose(irq_o));
  // R4
  reti_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti_i && !cli_i && !(irq_o && ack_i) |=> gie_o);
  // R5
  cli_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cli_i |=> !$rose(irq_o) && !gie_o);
  // R6
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we_i && !(irq_o && ack_i) |=> (pend_o & $past(pend_o)) == $past(pend_o));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
  .NUM_FLAG(NUM_FLAG), .IDX_W($clog2(NUM_FLAG+NUM_LEVEL+1)), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we_i), .insn_bnd_i(insn_bnd_i),
  .ack_i(ack_i), .reti_i(reti_i), .cli_i(cli_i), .irq_o(irq_o),
  .vec_idx_o(vec_idx_o), .vec_addr_o(vec_addr_o), .pend_o(pend_o), .gie_o(gie_o)
);

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic [3:0] evt_i = 0;
  logic [1:0] lvl_i = 0, reg_addr_i = 0;
  logic [5:0] reg_wdata_i = 0;
  logic reg_we_i = 0, insn_bnd_i = 0, ack_i = 0, reti_i = 0, cli_i = 0;
  logic irq_o, gie_o;
  logic [2:0] vec_idx_o;
  logic [11:0] vec_addr_o;
  logic [3:0] pend_o;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (.*);

  // fields: [15:12] events, [11:10] levels, [9:4] enables, [2:0] expected index
  localparam logic [15:0] VECS [8] = '{
    {4'b0001, 2'b00, 6'b111111, 1'b0, 3'd1},
    {4'b1010, 2'b00, 6'b111111, 1'b0, 3'd2},
    {4'b1100, 2'b00, 6'b111011, 1'b0, 3'd4},
    {4'b0000, 2'b01, 6'b111111, 1'b0, 3'd5},
    {4'b1000, 2'b11, 6'b111111, 1'b0, 3'd4},
    {4'b0000, 2'b10, 6'b011111, 1'b0, 3'd0},
    {4'b0110, 2'b00, 6'b111001, 1'b0, 3'd0},
    {4'b1111, 2'b11, 6'b100000, 1'b0, 3'd6}
  };

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d; tick();
    reg_we_i = 0; reg_wdata_i = 0;
  endtask
  task automatic evt(input logic [3:0] e); evt_i = e; tick(); evt_i = 0; endtask
  task automatic bnd(); insn_bnd_i = 1; tick(); insn_bnd_i = 0; endtask
  task automatic ack(); ack_i = 1; tick(); ack_i = 0; endtask
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    check("R11 irq", irq_o, 0);
    check("R11 idx", vec_idx_o, 0);
    check("R11 addr", vec_addr_o, 0);
    check("R11 gie", gie_o, 0);
    check("R11 pend", pend_o, 0);

    for (int k = 0; k < 8; k++) begin
      logic [15:0] v;
      v = VECS[k];
      wr(2'd1, 6'h3f);
      wr(2'd0, v[9:4]);
      lvl_i = v[11:10];
      evt(v[15:12]);
      wr(2'd2, 6'd1);
      bnd();
      check("R1 irq", irq_o, v[2:0] != 0);
      check("R1 idx", vec_idx_o, v[2:0]);
      check("R10 addr", vec_addr_o, v[2:0] * 2);
      if (k == 6) check("R6 masked flags kept", pend_o, 4'b0110);
      if (irq_o) begin
        ack();
        check("R3 gie after ack", gie_o, 0);
      end
      lvl_i = 0;
      wr(2'd2, 6'd0);
    end

    wr(2'd1, 6'h3f);
    wr(2'd0, 6'h04);
    evt(4'b0100);
    bnd();
    check("R6 no accept gie off", irq_o, 0);
    check("R6 flag held", pend_o, 4'b0100);
    wr(2'd2, 6'd1);
    check("R9 gie write", gie_o, 1);
    tick();
    check("R2 no boundary", irq_o, 0);
    bnd();
    check("R2 accept", irq_o, 1);
    check("R2 idx", vec_idx_o, 3);
    wr(2'd0, 6'h3f);
    evt(4'b0001);
    bnd();
    check("R2 vector held", vec_idx_o, 3);
    evt_i = 4'b0100; ack_i = 1; tick(); evt_i = 0; ack_i = 0;
    check("R3 irq drop", irq_o, 0);
    check("R3 event wins", pend_o, 4'b0101);
    wr(2'd2, 6'd1);
    bnd();
    check("R1 src0", vec_idx_o, 1);
    ack();
    check("R3 hw clear", pend_o, 4'b0100);

    evt(4'b1011);
    check("R6 set", pend_o, 4'b1111);
    wr(2'd1, 6'b000101);
    check("R7 w1c", pend_o, 4'b1010);
    wr(2'd1, 6'b000000);
    check("R7 zero", pend_o, 4'b1010);

    wr(2'd2, 6'd1);
    insn_bnd_i = 1; cli_i = 1; tick(); insn_bnd_i = 0; cli_i = 0;
    check("R5 block", irq_o, 0);
    check("R5 gie", gie_o, 0);
    wr(2'd2, 6'd1);
    bnd();
    check("R5 later accept", vec_idx_o, 2);
    ack();

    insn_bnd_i = 1; reti_i = 1; tick(); insn_bnd_i = 0; reti_i = 0;
    check("R4 reti cycle", irq_o, 0);
    check("R4 gie set", gie_o, 1);
    bnd();
    check("R4 next insn", vec_idx_o, 4);
    ack();
    evt(4'b0001);
    wr(2'd2, 6'd1);
    insn_bnd_i = 1; reti_i = 1; tick(); insn_bnd_i = 0; reti_i = 0;
    check("R4 nested reti", irq_o, 0);
    bnd();
    check("R4 nested next", vec_idx_o, 1);
    ack();

    wr(2'd0, 6'b001111);
    lvl_i = 2'b01; tick(); lvl_i = 0; tick();
    wr(2'd0, 6'h3f);
    wr(2'd2, 6'd1);
    bnd();
    check("R8 lost", irq_o, 0);
    lvl_i = 2'b01;
    bnd();
    check("R8 live", vec_idx_o, 5);
    lvl_i = 0; tick();
    check("R2 level gone", vec_idx_o, 5);
    ack();

    wr(2'd2, 6'b11);
    evt(4'b0010);
    bnd();
    check("R10 reloc", vec_addr_o, 12'h404);
    wr(2'd2, 6'b01);
    check("R10 latched", vec_addr_o, 12'h404);
    ack();
    evt(4'b0010);
    wr(2'd2, 6'b01);
    bnd();
    check("R10 plain", vec_addr_o, 12'h004);
    ack();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule